// File: doc/BRIEF.md
# Output Driver Fault Protection Supervisor

This block supervises an eight-channel current-sinking output driver. Each channel has a digital overcurrent comparator level; the block also watches a die over-temperature level and a supply undervoltage level. It decides which channels must be forced off, whether the whole driver must be disabled, and whether the active-low fault flag is pulled low. The flag is modelled as the level to be presented on an open-drain pin: 0 means the pin is pulled low.

An overcurrent level must persist for a programmable number of clock cycles (the short-pulse filter, standing in for a 2 µs window) before the channel latches off. A latched channel stays off after the overcurrent goes away, until the enable/reset input is raised or the block is reset. Over-temperature forces every channel off and pulls the flag low only while it lasts. Undervoltage acts exactly like a high enable/reset input. All inputs are asynchronous levels and pass through two-flop synchronizers; the reset is asserted asynchronously and released synchronously.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While and after reset, with all inputs low, `ch_off` is all zeros, `glob_off` is 0 and `flag_n` is 1.
- R2: Every input passes a two-flop synchronizer. An overcurrent level on channel i held for N consecutive clock cycles latches that channel if and only if N >= QUAL_CYC; a held level latches on the clock edge QUAL_CYC+2 cycles after it is first applied.
- R3: The qualification count restarts whenever the overcurrent level drops: two runs of QUAL_CYC-1 high cycles separated by one low cycle latch nothing.
- R4: Channels are independent: driving `oc_raw` with any bit mask long enough latches exactly that mask, `ch_off` (bit i is channel i) equals the mask, and no other channel is affected.
- R5: A latched channel keeps `ch_off[i]` = 1 after its overcurrent level is removed, and `flag_n` is 0 while any channel is latched.
- R6: While the synchronized enable/reset level is 1, `glob_off` is 1, all `ch_off` bits are 1, all latches and counters are cleared; after it falls, a channel whose overcurrent is still present must qualify for the full QUAL_CYC cycles again before relatching.
- R7: While over-temperature is present, all `ch_off` bits and `glob_off` are 1 and `flag_n` is 0; it is not latched, so on removal the outputs and flag return to what the channel latches alone dictate, and latched channels are kept.
- R8: Undervoltage behaves as a high enable/reset: all channels off, `glob_off` 1, latches cleared, and undervoltage alone never pulls `flag_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | NCH | Per-channel overcurrent comparator levels, 1 = overcurrent |
| ot_raw | input | 1 | Over-temperature level, 1 = too hot |
| uv_raw | input | 1 | Undervoltage level, 1 = supply too low |
| en_rst | input | 1 | Enable/reset level, 1 = outputs disabled and latched faults cleared |
| ch_off | output | NCH | Per-channel shutdown, 1 = channel forced off |
| glob_off | output | 1 | Whole-driver shutdown (over-temperature, enable/reset or undervoltage) |
| flag_n | output | 1 | Active-low fault flag level for the open-drain pin |

## Verification
The bench sweeps the pulse length around the filter limit, so a counter that is off by one either latches a QUAL_CYC-1 pulse or ignores a QUAL_CYC pulse, and a gap test catches a counter that holds rather than restarts when the level drops. All 256 channel masks are latched and checked, which exposes crossed or shared channel bits. After a one-cycle enable/reset pulse with overcurrent still present, the relatch moment is checked on both sides of the exact cycle, catching a design that keeps a partial count. Over-temperature and undervoltage are each applied over latched channels to show the first keeps latches and pulls the flag while the second clears them without pulling it.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  localparam int unsigned DEF_NCH      = 8;
  localparam int unsigned DEF_QUAL_CYC = 250;
  localparam int unsigned SYNC_STAGES  = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/dfs_reset_sync.sv
module dfs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/dfs_sync.sv
module dfs_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign q_sync = stab_q;
endmodule

// File: rtl/dfs_oc_channel.sv
module dfs_oc_channel #(
  parameter int unsigned QUAL_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_s,
  input  logic clr,
  output logic tripped
);
  import drv_fault_pkg::*;
  localparam int unsigned CW = cnt_width(QUAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          trip_q, trip_d;
  logic          cnt_en;

  // Counting is only meaningful while unlatched and not cleared.
  assign cnt_en = oc_s && !trip_q && !clr;

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (clr) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        trip_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  assign tripped = trip_q;

  // R5: a latch survives until a clear
  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clr) |=> trip_q);
  // R6: a clear always empties the latch
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !trip_q);
  // R2: a latch only appears after an overcurrent sample without clear
  a_r2_trip_needs_oc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> ($past(oc_s) && !$past(clr)));
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
  parameter int unsigned NCH      = drv_fault_pkg::DEF_NCH,
  parameter int unsigned QUAL_CYC = drv_fault_pkg::DEF_QUAL_CYC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_raw,
  input  logic           ot_raw,
  input  logic           uv_raw,
  input  logic           en_rst,
  output logic [NCH-1:0] ch_off,
  output logic           glob_off,
  output logic           flag_n
);
  localparam int unsigned SW = NCH + 3;

  logic           rst_i_n;
  logic [SW-1:0]  raw_bus, sync_bus;
  logic [NCH-1:0] oc_s;
  logic           ot_s, uv_s, en_s;
  logic           clr_all;
  logic [NCH-1:0] trip;

  dfs_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign raw_bus = {en_rst, uv_raw, ot_raw, oc_raw};

  dfs_sync #(.W(SW)) u_sync (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .d_async (raw_bus),
    .q_sync  (sync_bus)
  );

  assign oc_s = sync_bus[NCH-1:0];
  assign ot_s = sync_bus[NCH];
  assign uv_s = sync_bus[NCH+1];
  assign en_s = sync_bus[NCH+2];

  // Undervoltage is folded into the enable/reset path.
  assign clr_all = en_s | uv_s;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dfs_oc_channel #(.QUAL_CYC(QUAL_CYC)) u_ch (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .oc_s    (oc_s[g]),
      .clr     (clr_all),
      .tripped (trip[g])
    );
  end

  assign glob_off = clr_all | ot_s;
  assign ch_off   = trip | {NCH{glob_off}};
  assign flag_n   = ~((|trip) | ot_s);

  // R7: over-temperature turns everything off and pulls the flag
  a_r7_ot_all_off: assert property (@(posedge clk) disable iff (!rst_i_n)
    ot_s |-> ((&ch_off) && !flag_n));
  // R8: undervoltage empties the latches, so only heat can hold the flag low
  a_r8_uv_no_flag: assert property (@(posedge clk) disable iff (!rst_i_n)
    uv_s |=> (flag_n || ot_s));
  // R6: enable/reset high forces every channel off
  a_r6_en_all_off: assert property (@(posedge clk) disable iff (!rst_i_n)
    en_s |-> ((&ch_off) && glob_off));
  // R1: nothing is latched right after reset release
  a_r1_clean_start: assert property (@(posedge clk)
    $rose(rst_i_n) |-> (trip == '0));
endmodule

// File: tb/sim_drv_fault_supervisor.sv
`timescale 1ns/1ps
module sim_drv_fault_supervisor;
  localparam int NCH = 8;
  localparam int QC  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] oc_raw = '0;
  logic ot_raw = 1'b0, uv_raw = 1'b0, en_rst = 1'b0;
  logic [NCH-1:0] ch_off;
  logic glob_off, flag_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  drv_fault_supervisor #(.NCH(NCH), .QUAL_CYC(QC)) u0 (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .ot_raw(ot_raw),
    .uv_raw(uv_raw), .en_rst(en_rst), .ch_off(ch_off),
    .glob_off(glob_off), .flag_n(flag_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_pulse();
    en_rst = 1'b1; step(1); en_rst = 1'b0; step(4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=1 exp=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 ch_off in reset", ch_off, 0);
    chk("R1 flag in reset", flag_n, 1);
    rst_n = 1'b1;
    step(5);
    chk("R1 ch_off", ch_off, 0);
    chk("R1 glob_off", glob_off, 0);
    chk("R1 flag_n", flag_n, 1);

    // R2: pulse length sweep around the limit
    for (int n = 1; n <= QC + 2; n++) begin
      oc_raw[0] = 1'b1; step(n); oc_raw = '0; step(4);
      chk("R2 pulse latch", ch_off[0], (n >= QC) ? 1 : 0);
      chk("R5 flag by latch", flag_n, (n >= QC) ? 0 : 1);
      clear_pulse();
    end

    // R2: exact latch edge for a held level
    oc_raw[2] = 1'b1; step(QC + 1);
    chk("R2 not yet", ch_off[2], 0);
    step(1);
    chk("R2 latched on time", ch_off[2], 1);
    oc_raw = '0; step(3); clear_pulse();

    // R3: gap restarts the count
    oc_raw[1] = 1'b1; step(QC - 1); oc_raw = '0; step(1);
    oc_raw[1] = 1'b1; step(QC - 1); oc_raw = '0; step(4);
    chk("R3 restart", ch_off, 0);
    chk("R3 flag", flag_n, 1);

    // R4/R5: every mask
    for (int m = 0; m < 256; m++) begin
      oc_raw = m[7:0]; step(QC + 4); oc_raw = '0; step(3);
      chk("R4 mask", ch_off, m);
      chk("R5 flag", flag_n, (m == 0) ? 1 : 0);
      clear_pulse();
      chk("R6 cleared", ch_off, 0);
    end

    // R6: level hold and full requalification
    en_rst = 1'b1; step(3);
    chk("R6 all off", ch_off, 8'hFF);
    chk("R6 glob", glob_off, 1);
    en_rst = 1'b0; step(3);
    chk("R6 released", glob_off, 0);
    oc_raw[3] = 1'b1; step(QC + 4);
    chk("R6 pre", ch_off, 8'h08);
    en_rst = 1'b1; step(1); en_rst = 1'b0;
    step(QC + 1);
    chk("R6 requalify early", ch_off, 0);
    step(1);
    chk("R6 requalify on time", ch_off, 8'h08);
    oc_raw = '0; step(2); clear_pulse();

    // R7: over-temperature over latched channels, then alone
    oc_raw = 8'h05; step(QC + 4); oc_raw = '0; step(2);
    ot_raw = 1'b1; step(3);
    chk("R7 all off", ch_off, 8'hFF);
    chk("R7 glob", glob_off, 1);
    chk("R7 flag", flag_n, 0);
    ot_raw = 1'b0; step(3);
    chk("R7 latches kept", ch_off, 8'h05);
    chk("R7 glob drop", glob_off, 0);
    clear_pulse();
    ot_raw = 1'b1; step(3);
    chk("R7 flag alone", flag_n, 0);
    ot_raw = 1'b0; step(3);
    chk("R7 flag recovers", flag_n, 1);
    chk("R7 no latch", ch_off, 0);

    // R8: undervoltage acts as enable/reset
    oc_raw = 8'hA0; step(QC + 4); oc_raw = '0; step(2);
    chk("R8 pre", ch_off, 8'hA0);
    uv_raw = 1'b1; step(3);
    chk("R8 all off", ch_off, 8'hFF);
    chk("R8 glob", glob_off, 1);
    chk("R8 flag not pulled", flag_n, 1);
    uv_raw = 1'b0; step(3);
    chk("R8 latches cleared", ch_off, 0);
    chk("R8 glob drop", glob_off, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule